// File: doc/BRIEF.md
# Heartbeat Watchdog Reset Generator

This block supervises a processor by watching a heartbeat line that firmware must keep toggling. A free-running interval counter advances on every cycle of a fixed reference clock. Each transition of the heartbeat, rising or falling, sends the counter back to zero. If the heartbeat sits at one level for a full timeout window, the block raises a reset pulse of fixed width toward the processor. The same event zeroes the counter and sends a one-cycle strobe that clears the arming flip-flop of a downstream write-lock circuit.

Firmware uses the block in two ways. In normal operation it toggles the heartbeat to keep the processor alive. Before a sensitive routine it stops toggling on purpose, which produces a clean and complete reset. The elapsed count is exported so that neighbouring logic can decode timing windows measured from the last clear. With the default 20-bit counter and a 2 MHz reference clock, the timeout is 2^20 cycles, about 524 ms.

Top module: `hbw_watchdog`

## Requirements
- R1: With no heartbeat transition seen, `cpu_rst_o` rises on the 2^CNT_W-th rising clock edge after the counter was last cleared. At that edge `elapsed_o` reads 0.
- R2: Outside a reset pulse and between clears, `elapsed_o` increases by exactly one on every clock edge, starting from zero.
- R3: A heartbeat held constantly high and a heartbeat held constantly low both lead to a timeout. Only transitions count as refresh.
- R4: A heartbeat transition, in either direction, makes `elapsed_o` read 0 on the (SYNC_STAGES+1)-th clock edge after the change. With the default of two stages, that is the third edge.
- R5: Once raised, `cpu_rst_o` stays high for exactly PULSE_CYCLES clock cycles (default 16) and then falls synchronously.
- R6: `arm_clr_o` is high for exactly one cycle, the first cycle of each reset pulse, and is never high outside a pulse.
- R7: While `cpu_rst_o` is high, `elapsed_o` is held at 0 and heartbeat transitions have no effect. One edge after `cpu_rst_o` falls, `elapsed_o` reads 1.
- R8: Driving `rst_ni` low (asynchronous, active low) forces `cpu_rst_o`=0, `arm_clr_o`=0 and `elapsed_o`=0 at once. This also cuts short a reset pulse that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock that the interval counter advances on |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| heartbeat_i | input | 1 | Asynchronous heartbeat that firmware toggles to refresh the watchdog |
| cpu_rst_o | output | 1 | Active-high processor reset pulse, PULSE_CYCLES wide |
| arm_clr_o | output | 1 | One-cycle strobe in the first cycle of a pulse that clears the lock arming flip-flop |
| elapsed_o | output | CNT_W | Clock cycles since the counter was last cleared |

## Verification
A heartbeat change applied between edges has its effect on `elapsed_o` on the third rising edge: two synchronizer stages, then the clearing register. Until then the count keeps climbing. The timeout raises `cpu_rst_o` and `arm_clr_o` on the edge that follows the cycle in which the count sits at all ones. The pulse then lasts 16 edges, and the count restarts one edge after the fall. The bench drives every input on the falling clock edge and samples after a known number of rising edges, with the expected values worked out from these latencies. The asynchronous reset is checked a fraction of a nanosecond after it is applied.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

   // State of the reset pulse stretcher
   typedef enum logic {
      PS_IDLE = 1'b0,
      PS_HOLD = 1'b1
   } pulse_state_e;

   // Width of a down-counter able to hold the value n-1
   function automatic int unsigned down_cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/hbw_edge_detect.sv
module hbw_edge_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic edge_o
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   // Synchronizer chain: stage 0 samples the raw input
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) sync_q[0] <= 1'b0;
               else         sync_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) sync_q[s] <= 1'b0;
               else         sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   // Previous synchronized level, used to spot a transition
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_q[LAST];
   end

   assign edge_o = sync_q[LAST] ^ prev_q;

endmodule

// File: rtl/hbw_interval_counter.sv
module hbw_interval_counter #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             hold_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // Expiry: terminal count reached with no refresh and no pulse in flight
   assign expire_o = (cnt_q == CNT_MAX) && !clear_i && !hold_i;

   always_comb begin
      if (hold_i || clear_i || expire_o) cnt_d = '0;
      else                               cnt_d = cnt_q + CNT_ONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/hbw_pulse_stretch.sv
module hbw_pulse_stretch #(
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   output logic pulse_o,
   output logic first_o
);

   import hbw_pkg::*;

   logic first_q;

   generate
      if (PULSE_CYCLES == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pulse_q <= 1'b0;
            else         pulse_q <= fire_i && !pulse_q;
         end
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) first_q <= 1'b0;
            else         first_q <= fire_i && !pulse_q;
         end
         assign pulse_o = pulse_q;
      end else begin : g_multi
         localparam int unsigned PW = down_cnt_width(PULSE_CYCLES);
         localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES - 1);
         localparam logic [PW-1:0] DEC  = {{(PW-1){1'b0}}, 1'b1};

         pulse_state_e state_q;
         logic [PW-1:0] left_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               state_q <= PS_IDLE;
               left_q  <= '0;
            end else begin
               case (state_q)
                  PS_IDLE: begin
                     if (fire_i) begin
                        state_q <= PS_HOLD;
                        left_q  <= LOAD;
                     end
                  end
                  PS_HOLD: begin
                     if (left_q == '0) state_q <= PS_IDLE;
                     else              left_q  <= left_q - DEC;
                  end
                  default: state_q <= PS_IDLE;
               endcase
            end
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) first_q <= 1'b0;
            else         first_q <= fire_i && (state_q == PS_IDLE);
         end

         assign pulse_o = (state_q == PS_HOLD);
      end
   endgenerate

   assign first_o = first_q;

endmodule

// File: rtl/hbw_watchdog.sv
module hbw_watchdog #(
   parameter int unsigned CNT_W        = 20,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             heartbeat_i,
   output logic             cpu_rst_o,
   output logic             arm_clr_o,
   output logic [CNT_W-1:0] elapsed_o
);

   // Elaboration-time parameter checks
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("hbw_watchdog: CNT_W must lie in 2..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbw_watchdog: SYNC_STAGES must be at least 2");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("hbw_watchdog: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic hb_edge;
   logic expire;
   logic pulse;
   logic first;

   hbw_edge_detect #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (heartbeat_i),
      .edge_o  (hb_edge)
   );

   hbw_interval_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (hb_edge),
      .hold_i   (pulse),
      .count_o  (elapsed_o),
      .expire_o (expire)
   );

   hbw_pulse_stretch #(
      .PULSE_CYCLES (PULSE_CYCLES)
   ) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (expire),
      .pulse_o (pulse),
      .first_o (first)
   );

   assign cpu_rst_o = pulse;
   assign arm_clr_o = first;

endmodule

// File: rtl/hbw_checker.sv
module hbw_checker #(
   parameter int unsigned CNT_W        = 20,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             hb_edge_i,
   input logic             cpu_rst_i,
   input logic             arm_clr_i,
   input logic [CNT_W-1:0] elapsed_i
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // Length of the current reset pulse, counted independently
   logic [31:0] high_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        high_q <= '0;
      else if (cpu_rst_i) high_q <= high_q + 32'd1;
      else                high_q <= '0;
   end

   AST_TIMEOUT_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elapsed_i == CNT_MAX && !cpu_rst_i && !hb_edge_i) |=> (cpu_rst_i && elapsed_i == '0)); // R1

   AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elapsed_i != '0) |-> (elapsed_i == CNT_W'($past(elapsed_i) + 1'b1))); // R2

   AST_EDGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hb_edge_i && !cpu_rst_i) |=> (elapsed_i == '0)); // R4

   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cpu_rst_i) |-> (high_q == PULSE_CYCLES)); // R5

   AST_ARM_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_clr_i |-> cpu_rst_i); // R6

   AST_ARM_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_clr_i |=> !arm_clr_i); // R6

   AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_rst_i |-> (elapsed_i == '0)); // R7

endmodule

bind hbw_watchdog hbw_checker #(
   .CNT_W        (CNT_W),
   .PULSE_CYCLES (PULSE_CYCLES)
) u_hbw_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .hb_edge_i (hb_edge),
   .cpu_rst_i (cpu_rst_o),
   .arm_clr_i (arm_clr_o),
   .elapsed_i (elapsed_o)
);

// File: tb/tb_hbw_watchdog.sv
`timescale 1ns/1ps
module tb_hbw_watchdog;

   localparam int unsigned CNT_W  = 6;   // timeout of 64 cycles
   localparam int unsigned PULSE  = 16;
   localparam int unsigned NVEC   = 12;

   typedef struct packed {
      logic        tog;
      int unsigned hold;
      int unsigned exp_el;
      logic        exp_rst;
      logic        exp_arm;
   } vec_t;

   // {toggle heartbeat first, rising edges to run, elapsed, cpu_rst, arm_clr}
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 10, 10, 1'b0, 1'b0},  // R2 plain counting
      '{1'b1,  3,  0, 1'b0, 1'b0},  // R4 rise clears on 3rd edge
      '{1'b1, 20, 17, 1'b0, 1'b0},  // R4 fall clears, then R2 counting
      '{1'b1, 65, 62, 1'b0, 1'b0},  // R4 refresh avoids timeout
      '{1'b0,  1, 63, 1'b0, 1'b0},  // R3 held high, terminal count
      '{1'b0,  1,  0, 1'b1, 1'b1},  // R1 R3 timeout while high, R6 strobe
      '{1'b0,  1,  0, 1'b1, 1'b0},  // R6 strobe lasts one cycle
      '{1'b1, 14,  0, 1'b1, 1'b0},  // R7 edge ignored during pulse
      '{1'b0,  1,  0, 1'b0, 1'b0},  // R5 pulse ends after 16 cycles
      '{1'b0,  5,  5, 1'b0, 1'b0},  // R7 count resumes
      '{1'b0, 58, 63, 1'b0, 1'b0},  // R3 held low, terminal count
      '{1'b0,  1,  0, 1'b1, 1'b1}   // R1 R3 timeout while low
   };

   logic             clk = 1'b0;
   logic             rst_ni = 1'b0;
   logic             heartbeat = 1'b0;
   logic             cpu_rst;
   logic             arm_clr;
   logic [CNT_W-1:0] elapsed;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   int unsigned cycles   = 0;
   bit          done     = 1'b0;

   always #2 clk = ~clk;

   hbw_watchdog #(
      .CNT_W        (CNT_W),
      .SYNC_STAGES  (2),
      .PULSE_CYCLES (PULSE)
   ) dut (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .heartbeat_i (heartbeat),
      .cpu_rst_o   (cpu_rst),
      .arm_clr_o   (arm_clr),
      .elapsed_o   (elapsed)
   );

   task automatic check(input string req, input string what, input int unsigned got, input int unsigned exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic check_all(input string req, input int unsigned el, input logic rs, input logic ar);
      check(req, "elapsed_o", int'(elapsed), el);
      check(req, "cpu_rst_o", int'(cpu_rst), int'(rs));
      check(req, "arm_clr_o", int'(arm_clr), int'(ar));
   endtask

   task automatic run_edges(input int unsigned n);
      for (int unsigned i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run exceeded 20000 cycles");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #0.5;
      check_all("R8", 0, 1'b0, 1'b0);   // R8 reset state
      @(negedge clk);
      rst_ni = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         if (VECS[v].tog) heartbeat = ~heartbeat;
         run_edges(VECS[v].hold);
         check_all($sformatf("vector %0d", v), VECS[v].exp_el, VECS[v].exp_rst, VECS[v].exp_arm);
      end

      // R5: pulse is exactly 16 cycles wide
      run_edges(PULSE - 1);
      check("R5", "cpu_rst_o last pulse cycle", int'(cpu_rst), 1);
      run_edges(1);
      check("R5", "cpu_rst_o after pulse", int'(cpu_rst), 0);
      check("R7", "elapsed_o at release", int'(elapsed), 0);
      run_edges(1);
      check("R7", "elapsed_o one edge after release", int'(elapsed), 1);

      // R1: timeout from a count of 1 needs 63 more edges
      run_edges(62);
      check_all("R1", 63, 1'b0, 1'b0);
      run_edges(1);
      check_all("R1", 0, 1'b1, 1'b1);

      // R8: system reset aborts a pulse at once
      run_edges(3);
      rst_ni = 1'b0;
      #0.5;
      check_all("R8", 0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
      run_edges(5);
      check_all("R8", 5, 1'b0, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule